// File: doc/BRIEF.md
# Eight-bit accumulator processor core

This block is a compact single-issue processor that executes one 8-bit instruction per clock. Its register file holds four 8-bit registers, and register 0 serves as the accumulator. Each cycle the core presents its program counter on the instruction address port and decodes the returned byte. The opcode field is variable in length: the leading bits of the byte decide how many of the following bits belong to the opcode. What is left of the byte carries a 7-bit constant, a 5-bit branch offset, two register fields or a single register field.

The instruction set covers constant loads, register-to-register moves, add and subtract into the accumulator, loads and stores through a register that holds the address, and branches relative to the PC. A branch may be unconditional, may depend on the accumulator being zero, or may depend on it being non-zero. Both memory ports are plain combinational-read interfaces with no valid/ready handshake and no back-pressure. Whatever byte the instruction port returns in a cycle is consumed in that cycle, and so is the data read. A store is a single-cycle write strobe that the memory must accept on the next rising edge.

Top module: `acc8_core`

## Requirements
- R1: A synchronous reset with `rst` high clears the PC and all four registers to zero, and no store is issued while `rst` is high.
- R2: `imem_addr` always shows the PC. Every instruction that is not a branch advances the PC by one, and the PC wraps from 255 to 0.
- R3: A byte whose bit 7 is 0 writes its bits 6..0, zero-extended to 8 bits, into the accumulator (register 0).
- R4: Byte pattern 1110_ddss copies register ss into register dd. When dd is 0, the next instruction sees the new accumulator value.
- R5: Byte 1111_00rr sets the accumulator to accumulator plus register rr, modulo 256.
- R6: Byte 1111_01rr sets the accumulator to accumulator minus register rr, modulo 256.
- R7: Byte 1111_10rr drives `dmem_addr` with register rr and writes `dmem_rdata` into the accumulator.
- R8: Byte 1111_11rr drives `dmem_addr` with register rr and `dmem_wdata` with the accumulator, and asserts `dmem_we`. No other instruction asserts `dmem_we`.
- R9: Byte 100_ooooo branches unconditionally. The target is PC + 1 + the two's-complement 5-bit offset ooooo, taken modulo 256.
- R10: Byte 101_ooooo branches only when the accumulator is zero. Byte 110_ooooo branches only when the accumulator is non-zero. Both use the R9 target, and a branch that is not taken goes to PC + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction fetch address (the PC) |
| imem_data | input | 8 | Instruction byte at `imem_addr`, combinational |
| dmem_addr | output | 8 | Data memory address, taken from the operand register |
| dmem_wdata | output | 8 | Store data (the accumulator) |
| dmem_we | output | 1 | Store strobe, one cycle per store |
| dmem_rdata | input | 8 | Data memory read value at `dmem_addr`, combinational |

## Verification
The bench runs arithmetic operands that carry out of bit 7 and borrow below zero. A design that kept a ninth bit or saturated would store the wrong byte. Branches use the largest forward offset, the most negative offset, and a backward jump to address 0. A core that treated the offset as unsigned, or measured it from the branch's own address, would fetch from the wrong place. Both conditional branches are run with the accumulator at zero and at non-zero, which exposes a swapped condition. The bench also covers a move into the accumulator followed straight away by a store, the constant 0x7F, which shows whether it was sign-extended, and a full wrap of the PC through 255.

// File: rtl/acc8_pkg.sv
package acc8_pkg;

  localparam int INSN_W = 8;
  localparam int FLD_W  = 2;
  localparam int IMM_W  = 7;
  localparam int OFF_W  = 5;

  typedef enum logic [3:0] {
    OP_LDC, OP_BRA, OP_BZ, OP_BNE, OP_MOV,
    OP_ADD, OP_SUB, OP_LOAD, OP_STORE
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [FLD_W-1:0] rd;
    logic [FLD_W-1:0] rs;
    logic [IMM_W-1:0] imm;
    logic [OFF_W-1:0] off;
  } dec_t;

endpackage

// File: rtl/acc8_decode.sv
module acc8_decode
  import acc8_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  always_comb begin
    dec.rd  = insn[3:2];
    dec.rs  = insn[1:0];
    dec.imm = insn[IMM_W-1:0];
    dec.off = insn[OFF_W-1:0];
    casez (insn)
      8'b0???????: dec.op = OP_LDC;
      8'b100?????: dec.op = OP_BRA;
      8'b101?????: dec.op = OP_BZ;
      8'b110?????: dec.op = OP_BNE;
      8'b1110????: dec.op = OP_MOV;
      8'b111100??: dec.op = OP_ADD;
      8'b111101??: dec.op = OP_SUB;
      8'b111110??: dec.op = OP_LOAD;
      default:     dec.op = OP_STORE;
    endcase
  end
endmodule

// File: rtl/acc8_regfile.sv
module acc8_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 4,
  localparam int RIW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RIW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RIW-1:0] raddr,
  output logic [DW-1:0]  rdata,
  output logic [DW-1:0]  acc
);
  logic [DW-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)                           q[i] <= '0;
      else if (we && waddr == RIW'(i))   q[i] <= wdata;
    end
  end

  assign rdata = q[raddr];
  assign acc   = q[0];
endmodule

// File: rtl/acc8_exec.sv
module acc8_exec
  import acc8_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  dec_t              dec,
  input  logic [DW-1:0]     acc,
  input  logic [DW-1:0]     opr,
  input  logic [DW-1:0]     rd_data,
  input  logic [AW-1:0]     pc,
  output logic              wr_en,
  output logic [FLD_W-1:0]  wr_idx,
  output logic [DW-1:0]     wr_data,
  output logic              st_en,
  output logic [AW-1:0]     pc_next
);
  logic          taken;
  logic [AW-1:0] off_x;

  assign off_x = {{(AW-OFF_W){dec.off[OFF_W-1]}}, dec.off};

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = '0;
    wr_data = acc;
    st_en   = 1'b0;
    taken   = 1'b0;
    unique case (dec.op)
      OP_LDC:   begin wr_en = 1'b1; wr_data = DW'(dec.imm); end
      OP_MOV:   begin wr_en = 1'b1; wr_idx = dec.rd; wr_data = opr; end
      OP_ADD:   begin wr_en = 1'b1; wr_data = acc + opr; end
      OP_SUB:   begin wr_en = 1'b1; wr_data = acc - opr; end
      OP_LOAD:  begin wr_en = 1'b1; wr_data = rd_data; end
      OP_STORE: st_en = 1'b1;
      OP_BRA:   taken = 1'b1;
      OP_BZ:    taken = (acc == '0);
      OP_BNE:   taken = (acc != '0);
      default:  ;
    endcase
  end

  assign pc_next = pc + AW'(1) + (taken ? off_x : '0);
endmodule

// File: rtl/acc8_core.sv
module acc8_core
  import acc8_pkg::*;
#(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int NREG = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [AW-1:0]     imem_addr,
  input  logic [INSN_W-1:0] imem_data,
  output logic [AW-1:0]     dmem_addr,
  output logic [DW-1:0]     dmem_wdata,
  output logic              dmem_we,
  input  logic [DW-1:0]     dmem_rdata
);
  localparam int RIW = $clog2(NREG);

  logic [AW-1:0]    pc, pc_next;
  dec_t             dec;
  logic [DW-1:0]    acc, opr, wr_data;
  logic             wr_en, st_en;
  logic [FLD_W-1:0] wr_idx;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  acc8_decode u_dec (.insn(imem_data), .dec(dec));

  acc8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(RIW'(wr_idx)), .wdata(wr_data),
    .raddr(RIW'(dec.rs)), .rdata(opr), .acc(acc)
  );

  acc8_exec #(.DW(DW), .AW(AW)) u_ex (
    .dec(dec), .acc(acc), .opr(opr), .rd_data(dmem_rdata), .pc(pc),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .st_en(st_en), .pc_next(pc_next)
  );

  assign imem_addr  = pc;
  assign dmem_addr  = AW'(opr);
  assign dmem_wdata = acc;
  assign dmem_we    = st_en & ~rst;
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] imem_addr,
  input logic [7:0]    imem_data,
  input logic          dmem_we,
  input logic [DW-1:0] dmem_wdata
);
  logic [AW-1:0] off_x;
  logic          is_store;
  assign off_x    = {{(AW-5){imem_data[4]}}, imem_data[4:0]};
  assign is_store = (imem_data[7:2] == 6'b111111);

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> imem_addr == '0);

  assert_no_store_in_reset_R1: assert property (@(posedge clk)
    rst |-> !dmem_we);

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
    (imem_data[7] == 1'b0 || imem_data[7:5] == 3'b111)
      |=> imem_addr == $past(imem_addr) + AW'(1));

  assert_ldc_to_store_R3: assert property (@(posedge clk) disable iff (rst)
    (imem_data[7] == 1'b0)
      |=> (!is_store || dmem_wdata == DW'($past(imem_data[6:0]))));

  assert_store_only_R8: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> is_store);

  assert_bra_target_R9: assert property (@(posedge clk) disable iff (rst)
    (imem_data[7:5] == 3'b100)
      |=> imem_addr == $past(imem_addr) + AW'(1) + $past(off_x));
endmodule

bind acc8_core acc8_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_we(dmem_we), .dmem_wdata(dmem_wdata)
);

// File: tb/tb_acc8_core.sv
module tb_acc8_core;
  localparam int CLK_PERIOD = 10;

  // a, r, sub, expected
  localparam logic [24:0] VEC [6] = '{
    {8'd5,   8'd3,   1'b0, 8'd8},
    {8'd200, 8'd100, 1'b0, 8'd44},
    {8'd255, 8'd1,   1'b0, 8'd0},
    {8'd3,   8'd5,   1'b1, 8'd254},
    {8'd0,   8'd1,   1'b1, 8'd255},
    {8'd128, 8'd128, 1'b1, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic       dmem_we;
  logic [7:0] imem [256];
  logic [7:0] dmem [256];
  int         n_wr = 0;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) if (dmem_we) begin
    dmem[dmem_addr] <= dmem_wdata;
    n_wr <= n_wr + 1;
  end

  acc8_core dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) begin
      imem[i] = 8'hE5;   // MOV R1,R1
      dmem[i] = 8'h00;
    end
  endtask

  task automatic release_reset();
    @(negedge clk);
    @(negedge clk);
    rst  = 1'b0;
    n_wr = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Table walk: R5 R6 R7 R8 through load, arithmetic and store
    foreach (VEC[k]) begin
      hold_reset();
      imem[0] = 8'h20; imem[1] = 8'hEC; imem[2] = 8'h11; imem[3] = 8'hF8;
      imem[4] = 8'hE8; imem[5] = 8'h10; imem[6] = 8'hF8;
      imem[7] = VEC[k][8] ? 8'hF6 : 8'hF2;
      imem[8] = 8'hFF; imem[9] = 8'h9F;
      dmem[8'h10] = VEC[k][24:17];
      dmem[8'h11] = VEC[k][16:9];
      release_reset();
      run(12);
      chk(VEC[k][8] ? "R6 sub/R7 load/R8 store" : "R5 add/R7 load/R8 store",
          dmem[8'h20], VEC[k][7:0]);
      chk("R9 branch to self", imem_addr, 9);
    end

    // R1: reset state
    hold_reset();
    imem[0] = 8'hFD;              // STORE R1: address 0, data A
    dmem[0] = 8'hAA;
    @(negedge clk);
    chk("R1 no store in reset", dmem[0], 8'hAA);
    release_reset();
    chk("R1 pc after reset", imem_addr, 0);
    run(1);
    chk("R1 registers cleared", dmem[0], 0);

    // R2: sequential fetch and wrap; R8 no stray stores
    hold_reset();
    release_reset();
    run(1);
    chk("R2 pc step", imem_addr, 1);
    run(255);
    chk("R2 pc wrap", imem_addr, 0);
    chk("R8 no store from moves", n_wr, 0);

    // R3 zero-extended constant, R4 move into accumulator
    hold_reset();
    imem[0] = 8'h30; imem[1] = 8'hEC; imem[2] = 8'h7F; imem[3] = 8'hFF;
    imem[4] = 8'h31; imem[5] = 8'hEC; imem[6] = 8'h05; imem[7] = 8'hE4;
    imem[8] = 8'h09; imem[9] = 8'hE1; imem[10] = 8'hFF; imem[11] = 8'h9F;
    release_reset();
    run(14);
    chk("R3 constant zero-extended", dmem[8'h30], 8'h7F);
    chk("R4 move into accumulator", dmem[8'h31], 8'h05);
    chk("R8 exactly two stores", n_wr, 2);

    // R10 conditional branches
    hold_reset();
    imem[0] = 8'h00; imem[1] = 8'hA3; imem[5] = 8'hC4; imem[6] = 8'h01;
    imem[7] = 8'hA5; imem[8] = 8'hD7;
    release_reset();
    run(2);
    chk("R10 BZ taken", imem_addr, 5);
    run(1);
    chk("R10 BNE not taken", imem_addr, 6);
    run(2);
    chk("R10 BZ not taken", imem_addr, 8);
    run(1);
    chk("R10 BNE taken backward", imem_addr, 0);

    // R9 offset extremes
    hold_reset();
    imem[0] = 8'h8F; imem[16] = 8'h90;
    release_reset();
    run(1);
    chk("R9 offset +15", imem_addr, 16);
    run(1);
    chk("R9 offset -16", imem_addr, 1);

    // R1 reset in mid-run
    rst = 1'b1;
    run(2);
    rst = 1'b0;
    chk("R1 pc after mid-run reset", imem_addr, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule